// File: doc/BRIEF.md
# Full-Speed USB Receive Bit Recovery

This block recovers bit timing and line data from a full-speed (12 Mb/s) USB differential receive pair. It runs on a 48 MHz clock, which gives four sample slots per bit. Both data lines pass through a synchronizer. The block then watches the synchronized pair for transitions and keeps a slot counter aligned to them. Once per bit it emits the line state taken two slots after the most recent edge, which places the sample near mid-bit, together with a one-cycle valid strobe.

The alignment does not freeze after the first edge. Every later transition pulls the slot counter back toward alignment by at most one slot. A sender that runs slightly fast or slow then shows up as an occasional bit period of three or five clocks instead of four. A single-ended-zero bit is flagged on its own output, and a level output reports when the line has rested in the idle (J) state for a configurable number of bits. Downstream logic handles NRZI decoding, unstuffing, sync detection and packet checks, and takes its input from the strobe and state outputs.

Top module: `usb_bit_recover`

## Requirements
- R1: `bit_state` carries the recovered pair as {D+, D-}: 2'b10 is J, 2'b01 is K, 2'b00 is single-ended zero (SE0) and 2'b11 is SE1.
- R2: After reset, `bit_valid`, `bit_se0` and `line_idle` are low. No bit is produced while the synchronized pair has not changed since reset, however long the line is held.
- R3: When the first transition is driven onto the pins after reset, `bit_valid` rises exactly 5 clock cycles later with the new state. Those 5 cycles are two synchronizer stages, two slots to mid-bit and one output register.
- R4: Once locked, each run of L clocks of one line state, where L mod 4 is not 2, yields exactly floor((L+1)/4) recovered bits of that state, in order. For example, 4k clocks give k bits.
- R5: Runs of 3 or 5 clocks (a fast or slow sender) each yield one bit. The spacing between consecutive `bit_valid` pulses is always 3, 4 or 5 clocks.
- R6: A transition moves the sample point by at most one slot. A bit is never sampled in the same cycle in which a transition is detected.
- R7: `bit_se0` pulses together with `bit_valid` exactly when the recovered state is SE0.
- R8: `line_idle` rises with the IDLE_BITS-th consecutive recovered J bit (default 7) and falls with the first recovered bit that is not J.
- R9: Once a phase is established it is kept until reset. Reset clears it, so that after reset no bits appear until a new transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sample clock (four slots per bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_dp | input | 1 | Asynchronous D+ receive level |
| usb_dm | input | 1 | Asynchronous D- receive level |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| bit_state | output | 2 | Recovered line state {D+, D-} |
| bit_se0 | output | 1 | Strobe: recovered bit is SE0 |
| line_idle | output | 1 | Line has held J for IDLE_BITS bits |

## Verification
A slot counter that drifts or is corrected by the wrong amount shows up as a strobe spacing outside three to five clocks, or as a run yielding one bit too many or too few. This is visible within a single run of one line state, so no more than about three bit times pass before it appears. A lock flag set too early or cleared by mistake shows up as strobes on a quiet line, or as a missing strobe exactly five clocks after the first edge. A wrong idle run count moves the `line_idle` rise away from the seventh J bit, and a wrong SE0 decode pairs `bit_se0` with the wrong strobe.

// File: rtl/usbcdr_pkg.sv
package usbcdr_pkg;
   // Line state encoding is {D+, D-}
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_K   = 2'b01,
      LS_J   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;
endpackage

// File: rtl/usbcdr_sync.sv
module usbcdr_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("usbcdr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/usbcdr_phase.sv
module usbcdr_phase
   import usbcdr_pkg::*;
#(
   parameter int OS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line,
   output logic       strobe
);
   generate
      if (OS < 3) begin : g_bad_os
         $error("usbcdr_phase: OS must be at least 3");
      end
   endgenerate

   localparam int            CW   = $clog2(OS);
   localparam logic [CW-1:0] MID  = CW'(OS / 2);
   localparam logic [CW-1:0] LAST = CW'(OS - 1);

   logic [1:0]    prev;
   logic          locked;
   logic [CW-1:0] cnt, eff;
   logic          edge_seen;

   assign edge_seen = (line != prev);

   // Corrected slot for this cycle: full realign when unlocked,
   // otherwise a single slot toward zero.
   always_comb begin
      eff = cnt;
      if (edge_seen) begin
         if (!locked || cnt == '0 || cnt == LAST) eff = '0;
         else if (cnt <= MID)                     eff = cnt - 1'b1;
         else                                     eff = cnt + 1'b1;
      end
   end

   assign strobe = (locked || edge_seen) && (eff == MID);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev   <= LS_J;
         locked <= 1'b0;
         cnt    <= '0;
      end else begin
         prev <= line;
         if (edge_seen) locked <= 1'b1;
         cnt <= (eff == LAST) ? '0 : eff + 1'b1;
      end
   end

   AST_NO_SAMPLE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |-> !strobe);                                          // R6
   AST_NO_BIT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !edge_seen) |-> !strobe);                            // R2
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);                                              // R9
endmodule

// File: rtl/usbcdr_slicer.sv
module usbcdr_slicer
   import usbcdr_pkg::*;
#(
   parameter int IDLE_BITS = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe,
   input  logic [1:0] line,
   output logic       bit_valid,
   output logic [1:0] bit_state,
   output logic       bit_se0,
   output logic       line_idle
);
   generate
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("usbcdr_slicer: IDLE_BITS must be at least 1");
      end
   endgenerate

   localparam int            IW   = $clog2(IDLE_BITS + 1);
   localparam logic [IW-1:0] JMAX = IW'(IDLE_BITS);
   localparam logic [IW-1:0] JPRE = IW'(IDLE_BITS - 1);

   logic [IW-1:0] jrun;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_valid <= 1'b0;
         bit_state <= LS_J;
         bit_se0   <= 1'b0;
         line_idle <= 1'b0;
         jrun      <= '0;
      end else begin
         bit_valid <= strobe;
         bit_se0   <= strobe && (line == LS_SE0);
         if (strobe) begin
            bit_state <= line;
            if (line == LS_J) begin
               jrun      <= (jrun == JMAX) ? jrun : jrun + 1'b1;
               line_idle <= (jrun >= JPRE);
            end else begin
               jrun      <= '0;
               line_idle <= 1'b0;
            end
         end
      end
   end

   AST_SE0_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bit_se0 |-> (bit_valid && bit_state == LS_SE0));                 // R7
   AST_IDLE_RISE_ON_J: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_idle) |-> (bit_valid && bit_state == LS_J));          // R8
   AST_IDLE_FALL_ON_NONJ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_idle) |-> (bit_valid && bit_state != LS_J));          // R8
endmodule

// File: rtl/usb_bit_recover.sv
module usb_bit_recover
   import usbcdr_pkg::*;
#(
   parameter int OVERSAMPLE  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_BITS   = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       usb_dp,
   input  logic       usb_dm,
   output logic       bit_valid,
   output logic [1:0] bit_state,
   output logic       bit_se0,
   output logic       line_idle
);
   logic [1:0] line_sync;
   logic       strobe;

   usbcdr_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (2),
      .RST_VAL (LS_J)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({usb_dp, usb_dm}),
      .q     (line_sync)
   );

   usbcdr_phase #(
      .OS (OVERSAMPLE)
   ) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .line   (line_sync),
      .strobe (strobe)
   );

   usbcdr_slicer #(
      .IDLE_BITS (IDLE_BITS)
   ) u_slicer (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe),
      .line      (line_sync),
      .bit_valid (bit_valid),
      .bit_state (bit_state),
      .bit_se0   (bit_se0),
      .line_idle (line_idle)
   );
endmodule

// File: tb/usb_bit_recover_test.sv
module usb_bit_recover_test;
   localparam logic [1:0] J = 2'b10, K = 2'b01, Z = 2'b00;
   localparam int NRUN = 12;
   localparam logic [1:0] RUN_ST [NRUN] = '{K, J, K, J, K, J, K, J, K, Z, J, K};
   localparam int         RUN_LEN[NRUN] = '{4, 4, 4, 8, 12, 5, 5, 3, 3, 8, 4, 9};

   logic clk = 1'b0, rst_n = 1'b0, usb_dp = 1'b1, usb_dm = 1'b0;
   logic bit_valid, bit_se0, line_idle;
   logic [1:0] bit_state;

   always #5 clk = ~clk;

   usb_bit_recover uut (
      .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
      .bit_valid(bit_valid), .bit_state(bit_state),
      .bit_se0(bit_se0), .line_idle(line_idle)
   );

   int checks = 0, errs = 0;
   logic [1:0] cap [256];
   int cap_n = 0, since = 0, nse0 = 0;
   bit have = 1'b0, done = 1'b0;
   logic [1:0] expv [64];
   int nexp = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] st, input int n);
      {usb_dp, usb_dm} = st;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: capture bits, check spacing (R5) and SE0 flag (R7)
   always @(negedge clk) begin
      if (!rst_n) begin
         cap_n = 0; have = 1'b0; since = 0;
      end else if (bit_valid) begin
         if (have) chk((since + 1) >= 3 && (since + 1) <= 5, "R5 strobe spacing", since + 1, 4);
         chk(bit_se0 == (bit_state == Z), "R7 se0 flag", int'(bit_se0), int'(bit_state == Z));
         if (bit_se0) nse0++;
         if (cap_n < 256) cap[cap_n] = bit_state;
         cap_n++; have = 1'b1; since = 0;
      end else begin
         since++;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
         $finish;
      end
   end

   initial begin
      // Reset state (R2)
      drive(J, 3);
      chk(!bit_valid && !bit_se0 && !line_idle, "R2 reset outputs",
          int'({bit_valid, bit_se0, line_idle}), 0);
      rst_n = 1'b1;
      drive(J, 12);
      chk(cap_n == 0, "R2 no bits on quiet line", cap_n, 0);

      // First-edge latency (R3, R1)
      {usb_dp, usb_dm} = K;
      repeat (4) @(negedge clk);
      chk(!bit_valid, "R3 no strobe before 5 cycles", int'(bit_valid), 0);
      @(negedge clk);
      chk(bit_valid && bit_state == K, "R3 strobe at 5 cycles with K (R1)",
          int'({bit_valid, bit_state}), int'({1'b1, K}));

      // Reset clears lock (R9)
      rst_n = 1'b0;
      drive(J, 3);
      rst_n = 1'b1;
      drive(J, 20);
      chk(cap_n == 0, "R9 lock cleared by reset", cap_n, 0);

      // Vector table walk (R4, R5, R1)
      for (int i = 0; i < NRUN; i++) begin
         for (int k = 0; k < (RUN_LEN[i] + 1) / 4; k++) begin
            expv[nexp] = RUN_ST[i];
            nexp++;
         end
      end
      for (int i = 0; i < NRUN; i++) drive(RUN_ST[i], RUN_LEN[i]);
      drive(J, 40);
      chk(cap_n >= nexp + 7, "R4 bit count", cap_n, nexp + 7);
      for (int i = 0; i < nexp; i++)
         chk(cap[i] == expv[i], "R4 recovered sequence", int'(cap[i]), int'(expv[i]));
      for (int i = nexp; i < nexp + 7; i++)
         chk(cap[i] == J, "R4 trailing J bits", int'(cap[i]), int'(J));
      chk(line_idle, "R8 idle after long J", int'(line_idle), 1);
      chk(nse0 == 2, "R7 se0 bits in table", nse0, 2);

      // SE0 directed (R7, R8)
      drive(Z, 8);
      chk(!line_idle, "R8 idle drops on SE0", int'(line_idle), 0);
      drive(J, 4);
      chk(nse0 == 4, "R7 se0 pulse count", nse0, 4);

      // Idle rises exactly on 7th J bit (R8)
      drive(K, 4);
      rst_n = 1'b1;
      {usb_dp, usb_dm} = J;
      // first J bit appears 5 cycles after drive; the 7th one 24 cycles later
      repeat (5 + 6 * 4 - 1) @(negedge clk);
      chk(!line_idle, "R8 idle low after 6 J bits", int'(line_idle), 0);
      @(negedge clk);
      chk(line_idle && bit_valid, "R8 idle high on 7th J bit",
          int'({line_idle, bit_valid}), 3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end
endmodule